// File: doc/BRIEF.md
# Strobe-driven FIFO buffer with half-full flag and rewind

This block is a first-in first-out store for 9-bit words. It is controlled by separate active-low write and read strobes and reports its state on three active-low flags: full, empty and half-full. All strobes are sampled in one system clock domain. An operation is triggered by a strobe's falling edge and finished by its rising edge. The read data bus, which in a pad ring would be tri-state, is given here as a data output with a separate output-enable.

A rewind input moves the read position back to the first word stored since reset and leaves the write position where it is. Previously read data can then be replayed. The flags are then derived again from the restored occupancy. The depth is a parameter. The default is 16 words, and a build may use a depth such as 16384. The block always works as a single stand-alone buffer.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is low and after it is released, empty_n is 0, full_n is 1, half_n is 1, dout_oe is 0 and dout is all zeros.
- R2: A falling edge on wr_n while full_n is 1 stores din at the next location. Words are returned by reads in the order they were stored.
- R3: full_n goes to 0 on the write falling edge that brings the occupancy to DEPTH. While full_n is 0, write strobes change nothing. full_n returns to 1 on a read rising edge once the occupancy is below DEPTH.
- R4: empty_n goes to 0 on the read falling edge that removes the last word. While empty_n is 0, a read strobe leaves dout_oe at 0 and removes nothing. empty_n returns to 1 on a write rising edge once the occupancy is above zero.
- R5: half_n goes to 0 on a write falling edge that makes the occupancy exceed DEPTH/2. It returns to 1 on a read rising edge once the occupancy is DEPTH/2 or less.
- R6: From an accepted read falling edge until the read rising edge, dout_oe is 1 and dout holds the oldest stored word. After the rising edge, dout_oe is 0 and dout is all zeros.
- R7: When a write and a read start in the same clock with both allowed, the occupancy is unchanged and the read returns the older word, not the one being written.
- R8: A falling edge on rt_n while wr_n and rd_n are both high restarts reading at the first word written since reset. The occupancy becomes the number of words written since reset, capped at DEPTH. empty_n, full_n and half_n are recomputed from it: empty_n = (count != 0), full_n = (count != DEPTH), half_n = !(count > DEPTH/2). Later writes append after the last written word.
- R9: A falling edge on rt_n while either strobe is low is ignored: reading continues from the current position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind request |
| din | input | W | Write data, held stable while wr_n is low |
| dout | output | W | Read data, zero when not enabled |
| dout_oe | output | 1 | High while read data is being driven |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| half_n | output | 1 | Low when more than half full |

## Verification
The bench alternates plain write runs with read runs. Runs fill the buffer to DEPTH, drain it to zero and cross DEPTH/2 in both directions, which separates the set and release points of each flag. Writes at full, reads at empty and writes that overlap a read in the same clock show that blocked and concurrent strobes do not disturb the order or the occupancy. Rewinds are tried with a partial fill, with a fill of exactly DEPTH and with data appended afterwards, and one rewind is issued while a write strobe is held low. These cases tell a correct rewind apart from an ignored one and from one that also moves the write position.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
    // Events derived from one sampled active-low strobe
    typedef struct packed {
        logic fall;   // strobe went low between the last two samples
        logic rise;   // strobe went high between the last two samples
        logic idle;   // strobe high in both samples
    } strobe_ev_t;
endpackage

// File: rtl/strobe_fifo_edge.sv
module strobe_fifo_edge
    import fifo_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           strobe_n,
    output strobe_ev_t [N-1:0]     ev_o
);
    logic [N-1:0] smp_q;
    logic [N-1:0] prv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '1;
            prv_q <= '1;
        end else begin
            smp_q <= strobe_n;
            prv_q <= smp_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_evt
        assign ev_o[i].fall = prv_q[i] & ~smp_q[i];
        assign ev_o[i].rise = ~prv_q[i] & smp_q[i];
        assign ev_o[i].idle = prv_q[i] & smp_q[i];
    end
endmodule

// File: rtl/strobe_fifo_ram.sv
module strobe_fifo_ram #(
    parameter int W     = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_ev_t    ev_wr,
    input  strobe_ev_t    ev_rd,
    input  strobe_ev_t    ev_rt,
    output logic          wr_go_o,
    output logic [AW-1:0] waddr_o,
    output logic          rd_go_o,
    output logic [AW-1:0] raddr_o,
    output logic          full_n_o,
    output logic          empty_n_o,
    output logic          half_n_o,
    output logic          oe_o
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;    // words currently held
        logic [CW-1:0] tot;    // words written since reset, saturating
        logic          full_n;
        logic          empty_n;
        logic          half_n;
        logic          oe;
    } st_t;

    st_t  s_q, s_d;
    logic wr_go, rd_go, rt_go;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        s_d   = s_q;
        wr_go = ev_wr.fall && s_q.full_n;
        rd_go = ev_rd.fall && s_q.empty_n;
        rt_go = ev_rt.fall && ev_wr.idle && ev_rd.idle;

        if (rt_go) begin
            s_d.rptr    = '0;
            s_d.cnt     = s_q.tot;
            s_d.empty_n = (s_q.tot != '0);
            s_d.full_n  = (s_q.tot != CW'(DEPTH));
            s_d.half_n  = !(s_q.tot > CW'(HALF));
        end else begin
            if (wr_go) begin
                s_d.wptr = ptr_inc(s_q.wptr);
                if (s_q.tot != CW'(DEPTH)) s_d.tot = s_q.tot + CW'(1);
            end
            if (rd_go) begin
                s_d.rptr = ptr_inc(s_q.rptr);
                s_d.oe   = 1'b1;
            end
            s_d.cnt = s_q.cnt + CW'(wr_go) - CW'(rd_go);

            // Assert-edge flag updates
            if (wr_go && s_d.cnt == CW'(DEPTH)) s_d.full_n  = 1'b0;
            if (wr_go && s_d.cnt >  CW'(HALF))  s_d.half_n  = 1'b0;
            if (rd_go && s_d.cnt == '0)         s_d.empty_n = 1'b0;

            // Release-edge flag updates
            if (ev_wr.rise && s_d.cnt != '0) s_d.empty_n = 1'b1;
            if (ev_rd.rise) begin
                s_d.oe = 1'b0;
                if (s_d.cnt <  CW'(DEPTH)) s_d.full_n = 1'b1;
                if (s_d.cnt <= CW'(HALF))  s_d.half_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.full_n  <= 1'b1;
            s_q.half_n  <= 1'b1;
            s_q.empty_n <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_go_o   = wr_go;
    assign waddr_o   = s_q.wptr;
    assign rd_go_o   = rd_go;
    assign raddr_o   = s_q.rptr;
    assign full_n_o  = s_q.full_n;
    assign empty_n_o = s_q.empty_n;
    assign half_n_o  = s_q.half_n;
    assign oe_o      = s_q.oe;

    a_r3_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.full_n && ev_wr.fall) |=> $stable(s_q.wptr));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    a_r4_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.empty_n && ev_rd.fall) |=> $stable(s_q.rptr));

    a_r5_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.full_n |-> !s_q.half_n);

    a_r6_oe_off_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd.rise |=> !s_q.oe);

    a_r7_overlap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr.fall && ev_rd.fall && s_q.full_n && s_q.empty_n) |=> $stable(s_q.cnt));

    a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rt.fall && ev_wr.idle && ev_rd.idle) |=> (s_q.rptr == '0 && $stable(s_q.wptr)));

    a_r9_rewind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rt.fall && !(ev_wr.idle && ev_rd.idle) && !ev_rd.fall) |=> $stable(s_q.rptr));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_n,
    input  logic         rd_n,
    input  logic         rt_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_oe,
    output logic         full_n,
    output logic         empty_n,
    output logic         half_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_pkg::strobe_ev_t [2:0] ev;
    logic          wr_go, rd_go;
    logic [AW-1:0] waddr, raddr;
    logic [W-1:0]  rdata;

    strobe_fifo_edge #(.N(3)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({rt_n, rd_n, wr_n}),
        .ev_o     (ev)
    );

    strobe_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_wr     (ev[0]),
        .ev_rd     (ev[1]),
        .ev_rt     (ev[2]),
        .wr_go_o   (wr_go),
        .waddr_o   (waddr),
        .rd_go_o   (rd_go),
        .raddr_o   (raddr),
        .full_n_o  (full_n),
        .empty_n_o (empty_n),
        .half_n_o  (half_n),
        .oe_o      (dout_oe)
    );

    strobe_fifo_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_go),
        .waddr (waddr),
        .wdata (din),
        .re    (rd_go),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign dout = dout_oe ? rdata : '0;
endmodule

// File: tb/sim_strobe_fifo.sv
module sim_strobe_fifo;
    localparam int W = 9;
    localparam int D = 16;
    localparam int H = D / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic dout_oe, full_n, empty_n, half_n;

    always #2 clk = ~clk;   // 250 MHz

    strobe_fifo #(.W(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [W-1:0] q[$];      // scoreboard: expected read order
    logic [W-1:0] hist[$];   // words written since reset
    int  m_cnt, m_tot;
    logic m_full_n, m_empty_n, m_half_n;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_flags(input string tag);
        chk({"R3 full_n ", tag}, 32'(full_n), 32'(m_full_n));
        chk({"R4 empty_n ", tag}, 32'(empty_n), 32'(m_empty_n));
        chk({"R5 half_n ", tag}, 32'(half_n), 32'(m_half_n));
    endtask

    // Monitor: compare each newly enabled read word with the scoreboard
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (dout_oe && !oe_prev) begin
            if (q.size() == 0) chk("R2 unexpected read data", 32'(dout), 32'hFFFF_FFFF);
            else chk("R2/R6 read data order", 32'(dout), 32'(q.pop_front()));
        end
        oe_prev = dout_oe;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        q.delete(); hist.delete();
        m_cnt = 0; m_tot = 0; m_full_n = 1; m_empty_n = 0; m_half_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Write fall model (no release)
    task automatic model_wr_fall(input logic [W-1:0] d, input bit rok);
        bit wok;
        wok = m_full_n;
        if (wok) begin
            q.push_back(d); hist.push_back(d);
            if (m_tot < D) m_tot++;
        end
        m_cnt = m_cnt + (wok ? 1 : 0) - (rok ? 1 : 0);
        if (wok && m_cnt == D) m_full_n = 0;
        if (wok && m_cnt > H)  m_half_n = 0;
        if (rok && m_cnt == 0) m_empty_n = 0;
    endtask

    // One strobe cycle: optional write and/or read, assert then release
    task automatic op(input bit do_wr, input bit do_rd, input logic [W-1:0] d);
        bit rok;
        @(negedge clk);
        din = d;
        rok = do_rd && m_empty_n;
        if (do_wr) wr_n = 1'b0;
        if (do_rd) rd_n = 1'b0;
        if (do_wr) model_wr_fall(d, rok);
        else begin
            m_cnt = m_cnt - (rok ? 1 : 0);
            if (rok && m_cnt == 0) m_empty_n = 0;
        end
        repeat (3) @(negedge clk);
        if (do_rd) chk("R4/R6 dout_oe during read", 32'(dout_oe), 32'(rok));
        chk_flags("after assert edge");
        wr_n = 1'b1; rd_n = 1'b1;
        if (do_wr && m_cnt > 0) m_empty_n = 1;
        if (do_rd) begin
            if (m_cnt < D)  m_full_n = 1;
            if (m_cnt <= H) m_half_n = 1;
        end
        repeat (3) @(negedge clk);
        if (do_rd) begin
            chk("R6 dout_oe after release", 32'(dout_oe), 32'd0);
            chk("R6 dout zero after release", 32'(dout), 32'd0);
        end
        chk_flags("after release edge");
    endtask

    task automatic rewind(input bit accepted);
        @(negedge clk);
        rt_n = 1'b0;
        if (accepted) begin
            q = hist;
            m_cnt = m_tot;
            m_empty_n = (m_cnt != 0);
            m_full_n  = (m_cnt != D);
            m_half_n  = !(m_cnt > H);
        end
        repeat (3) @(negedge clk);
        rt_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_flags(accepted ? "R8 after rewind" : "R9 after ignored rewind");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 empty_n", 32'(empty_n), 32'd0);
        chk("R1 full_n", 32'(full_n), 32'd1);
        chk("R1 half_n", 32'(half_n), 32'd1);
        chk("R1 dout_oe", 32'(dout_oe), 32'd0);
        chk("R1 dout", 32'(dout), 32'd0);

        // R4: read while empty is ignored
        op(0, 1, '0);

        // R2: short write/read run
        for (int i = 0; i < 3; i++) op(1, 0, 9'h0A0 + 9'(i));
        for (int i = 0; i < 2; i++) op(0, 1, '0);

        // R7: overlapping write and read
        op(1, 1, 9'h155);
        op(1, 1, 9'h0AA);

        // R3/R5: fill to DEPTH, then a blocked write
        while (m_cnt < D) op(1, 0, 9'h100 + 9'(m_cnt));
        op(1, 0, 9'h1FF);
        op(1, 0, 9'h1FE);

        // R3/R4/R5: drain completely, then one extra read
        while (m_cnt > 0) op(0, 1, '0);
        op(0, 1, '0);

        // R8: partial fill, partial read, rewind, append
        do_reset();
        for (int i = 0; i < 10; i++) op(1, 0, 9'h020 + 9'(i));
        for (int i = 0; i < 4; i++) op(0, 1, '0);
        rewind(1);
        op(1, 0, 9'h1C3);
        while (m_cnt > 0) op(0, 1, '0);
        chk("R8 scoreboard drained", 32'(q.size()), 32'd0);

        // R8: rewind after exactly DEPTH words
        do_reset();
        for (int i = 0; i < D; i++) op(1, 0, 9'h040 + 9'(i));
        for (int i = 0; i < 3; i++) op(0, 1, '0);
        rewind(1);
        while (m_cnt > 0) op(0, 1, '0);

        // R9: rewind while the write strobe is held low
        do_reset();
        for (int i = 0; i < 6; i++) op(1, 0, 9'h060 + 9'(i));
        for (int i = 0; i < 2; i++) op(0, 1, '0);
        @(negedge clk);
        din = 9'h0EE;
        wr_n = 1'b0;
        model_wr_fall(9'h0EE, 0);
        repeat (3) @(negedge clk);
        rewind(0);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_flags("R9 after held write");
        while (m_cnt > 0) op(0, 1, '0);
        op(0, 1, '0);
        chk("R9 scoreboard drained", 32'(q.size()), 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule